// File: doc/BRIEF.md
# Paged Outbound Address Translator

This block widens the address of each outbound memory request before the request goes on to packet formation. A request carries a narrow local address. Its bits just above the page offset select one entry of a programmable table. All entries describe pages of the same power-of-two size. The selected entry's 64-bit base takes the place of every address bit at or above the page boundary. The offset inside the page passes through untouched.

Each entry also carries a 2-bit address-space attribute. The attribute marks the translated target as a 32-bit or a 64-bit address, and flags the reserved codes. The table is loaded 32 bits at a time through a small configuration port, which can also read entries back. Requests enter through a ready/valid handshake. Results leave one cycle later through a second ready/valid handshake, and the output holds while the consumer stalls.

The output stage is a two-state machine:
- **ST_EMPTY**: no result is held.
- **ST_FULL**: a result is presented.

Its transitions are:
- **ST_EMPTY → ST_FULL** when a request is accepted.
- **ST_FULL → ST_FULL** on a stall, or when the held result is taken while a new request is accepted in the same cycle.
- **ST_FULL → ST_EMPTY** when the held result is taken and no new request is offered.

Top module: `otx_page_xlate`

## Requirements
- R1: After reset every table entry reads back as zero, with attribute 00. The output is not valid and `req_ready` is 1.
- R2: A configuration write takes effect at the next clock edge. With `cfg_hi`=1 the write stores base bits 63:32. With `cfg_hi`=0 the write stores base bits 31:PAGE_BITS and the attribute, taken from data bits 1:0. A low-word read returns bits PAGE_BITS-1:2 as zero and returns the attribute in bits 1:0.
- R3: For an in-window request, the entry index is `req_addr[PAGE_BITS +: IDX_W]`. `out_addr` is the entry base for bits 63:PAGE_BITS and `req_addr` for bits PAGE_BITS-1:0.
- R4: Attribute 00 (32-bit target) forces `out_addr[63:32]` to zero. Attribute 01 (64-bit target) keeps all 64 bits. `out_attr` reports the entry's attribute.
- R5: Attribute 10 or 11 is reserved. A request that selects such an entry is still translated, and `out_err` is 1.
- R6: A request with `req_addr >> PAGE_BITS` at or above NUM_ENTRIES is out of the window. It passes through zero-extended, with `out_attr`=00 and `out_err`=1.
- R7: A request accepted at a clock edge (`req_valid && req_ready`) is presented on the output after that edge. `req_ready` equals `!out_valid || out_ready`.
- R8: While `out_valid` is 1 and `out_ready` is 0, the output values stay unchanged and no new request is accepted.
- R9: A request accepted in the same cycle as a configuration write to its entry is translated with the entry's value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Entry index for write and read |
| cfg_hi | input | 1 | Word select: 1 selects the upper 32 bits, 0 selects the lower word with the attribute |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read-back of the selected word |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | IN_AW | Local request address |
| out_valid | output | 1 | Translated result valid |
| out_ready | input | 1 | Consumer ready |
| out_addr | output | 64 | Translated address |
| out_attr | output | 2 | Address-space attribute of the selected entry |
| out_err | output | 1 | Out-of-window or reserved-attribute flag |

## Verification
Some rules are checked by assertions on every cycle:
- the stall hold and the blocked input;
- the output becoming valid after each accepted request;
- the zero upper half for 32-bit targets;
- the error flag for reserved attributes;
- the high-word write landing in the table.

The bench scenarios are the only place the following are shown: the full translated value against a model table, the pass-through outside the window, the read-back masking of the low word, and the old-value rule when a write and a request coincide. The same holds for the ordering of results under a pseudo-random stall pattern.

// File: rtl/otx_pkg.sv
package otx_pkg;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_st_t;

    localparam logic [1:0] ATTR_A32 = 2'b00;
    localparam logic [1:0] ATTR_A64 = 2'b01;

    typedef struct packed {
        logic [63:0] addr;
        logic [1:0]  attr;
        logic        err;
    } xlate_res_t;

endpackage

// File: rtl/otx_xlate_table.sv
module otx_xlate_table #(
    parameter int NUM_ENTRIES = 6,
    parameter int IDX_W       = 3,
    parameter int PAGE_BITS   = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_hi,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             rd_hi,
    output logic [31:0]      rd_data,
    input  logic [IDX_W-1:0] lk_idx,
    output logic [63:0]      lk_base,
    output logic [1:0]       lk_attr
);
    localparam logic [63:0] BASE_MASK = ~((64'd1 << PAGE_BITS) - 64'd1);

    logic [NUM_ENTRIES-1:0][63:0] base_all;
    logic [NUM_ENTRIES-1:0][1:0]  attr_all;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        logic [63:0] base_r;
        logic [1:0]  attr_r;
        logic        hit;

        assign hit = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_r <= '0;
                attr_r <= 2'b00;
            end else if (hit) begin
                if (wr_hi) begin
                    base_r[63:32] <= wr_data & BASE_MASK[63:32];
                end else begin
                    base_r[31:0] <= wr_data & BASE_MASK[31:0];
                    attr_r       <= wr_data[1:0];
                end
            end
        end

        assign base_all[e] = base_r;
        assign attr_all[e] = attr_r;

        AST_HI_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            hit && wr_hi |=> base_r[63:32] == ($past(wr_data) & BASE_MASK[63:32])); // R2
    end

    always_comb begin
        rd_data = '0;
        if (32'(rd_idx) < NUM_ENTRIES) begin
            rd_data = rd_hi ? base_all[rd_idx][63:32]
                            : (base_all[rd_idx][31:0] | {30'd0, attr_all[rd_idx]});
        end
    end

    always_comb begin
        lk_base = '0;
        lk_attr = 2'b00;
        if (32'(lk_idx) < NUM_ENTRIES) begin
            lk_base = base_all[lk_idx];
            lk_attr = attr_all[lk_idx];
        end
    end

endmodule

// File: rtl/otx_xlate_core.sv
module otx_xlate_core
    import otx_pkg::*;
#(
    parameter int NUM_ENTRIES = 6,
    parameter int IDX_W       = 3,
    parameter int PAGE_BITS   = 12,
    parameter int IN_AW       = 32
) (
    input  logic [IN_AW-1:0] req_addr,
    output logic [IDX_W-1:0] lk_idx,
    input  logic [63:0]      lk_base,
    input  logic [1:0]       lk_attr,
    output xlate_res_t       res
);
    localparam int          UPW       = IN_AW - PAGE_BITS;
    localparam logic [UPW-1:0] LIMIT  = UPW'(NUM_ENTRIES);
    localparam logic [63:0] BASE_MASK = ~((64'd1 << PAGE_BITS) - 64'd1);

    logic [UPW-1:0] page_num;
    logic           in_window;
    logic [63:0]    wide_addr;

    assign page_num  = req_addr[IN_AW-1:PAGE_BITS];
    assign in_window = page_num < LIMIT;
    assign lk_idx    = page_num[IDX_W-1:0];
    assign wide_addr = 64'(req_addr);

    always_comb begin
        if (!in_window) begin
            res.addr = wide_addr;
            res.attr = ATTR_A32;
            res.err  = 1'b1;
        end else begin
            res.addr = (lk_base & BASE_MASK) | (wide_addr & ~BASE_MASK);
            if (lk_attr == ATTR_A32) begin
                res.addr[63:32] = '0;
            end
            res.attr = lk_attr;
            res.err  = lk_attr[1];
        end
    end

endmodule

// File: rtl/otx_out_stage.sv
module otx_out_stage
    import otx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  xlate_res_t in_res,
    output logic       out_valid,
    input  logic       out_ready,
    output xlate_res_t out_res
);
    stage_st_t  state_q, state_d;
    xlate_res_t res_q;
    logic       accept;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_FULL;
            end
            ST_FULL: begin
                out_valid = 1'b1;
                in_ready  = out_ready;
                if (out_ready && !in_valid) state_d = ST_EMPTY;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (accept) begin
            res_q <= in_res;
        end
    end

    assign out_res = res_q;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_res)); // R8
    AST_NO_ACCEPT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R8
    AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R7
    AST_A32_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_res.attr == ATTR_A32 |-> out_res.addr[63:32] == 32'd0); // R4
    AST_RESV_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_res.attr[1] |-> out_res.err); // R5

endmodule

// File: rtl/otx_page_xlate.sv
module otx_page_xlate
    import otx_pkg::*;
#(
    parameter int NUM_ENTRIES = 6,
    parameter int PAGE_BITS   = 12,
    parameter int IN_AW       = 32,
    parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic             cfg_hi,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IN_AW-1:0] req_addr,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [63:0]      out_addr,
    output logic [1:0]       out_attr,
    output logic             out_err
);
    logic [IDX_W-1:0] lk_idx;
    logic [63:0]      lk_base;
    logic [1:0]       lk_attr;
    xlate_res_t       comb_res;
    xlate_res_t       held_res;

    otx_xlate_table #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .IDX_W      (IDX_W),
        .PAGE_BITS  (PAGE_BITS)
    ) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_hi  (cfg_hi),
        .wr_data(cfg_wdata),
        .rd_idx (cfg_idx),
        .rd_hi  (cfg_hi),
        .rd_data(cfg_rdata),
        .lk_idx (lk_idx),
        .lk_base(lk_base),
        .lk_attr(lk_attr)
    );

    otx_xlate_core #(
        .NUM_ENTRIES(NUM_ENTRIES),
        .IDX_W      (IDX_W),
        .PAGE_BITS  (PAGE_BITS),
        .IN_AW      (IN_AW)
    ) u_core (
        .req_addr(req_addr),
        .lk_idx  (lk_idx),
        .lk_base (lk_base),
        .lk_attr (lk_attr),
        .res     (comb_res)
    );

    otx_out_stage u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_res   (comb_res),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_res  (held_res)
    );

    assign out_addr = held_res.addr;
    assign out_attr = held_res.attr;
    assign out_err  = held_res.err;

endmodule

// File: tb/otx_page_xlate_tb.sv
module otx_page_xlate_tb;
    localparam int NE = 6;
    localparam int PB = 12;
    localparam int AW = 32;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic          cfg_hi = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [63:0]   out_addr;
    logic [1:0]    out_attr;
    logic          out_err;

    int checks = 0;
    int fails  = 0;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    logic [63:0] m_base [NE];
    logic [1:0]  m_attr [NE];
    logic [66:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    otx_page_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
        .out_attr(out_attr), .out_err(out_err)
    );

    task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [66:0] model(input logic [AW-1:0] a);
        logic [63:0] o;
        int          pg;
        pg = int'(a >> PB);
        if (pg >= NE) return {64'(a), 2'b00, 1'b1};
        o = {m_base[pg][63:PB], a[PB-1:0]};
        if (m_attr[pg] == 2'b00) o[63:32] = '0;
        return {o, m_attr[pg], m_attr[pg][1]};
    endfunction

    task automatic model_write(input int i, input bit hi, input logic [31:0] d);
        if (hi) begin
            m_base[i][63:32] = d;
        end else begin
            m_base[i][31:0] = d & 32'hFFFF_F000;
            m_attr[i] = d[1:0];
        end
    endtask

    task automatic cfg_write(input int i, input bit hi, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = IW'(i); cfg_hi = hi; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_we = 1'b0;
        model_write(i, hi, d);
    endtask

    task automatic cfg_read(input string tag, input int i, input bit hi, input logic [31:0] exp);
        @(negedge clk);
        cfg_idx = IW'(i); cfg_hi = hi;
        #1 check(tag, {35'd0, cfg_rdata}, {35'd0, exp});
    endtask

    task automatic send(input string tag, input logic [AW-1:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
        @(posedge clk);
        #1 req_valid = 1'b0;
        check("R7 valid after accept", {66'd0, out_valid}, {66'd0, 1'b1});
    endtask

    // monitor: pick ready for the next edge, then score the result that edge takes
    logic        prev_hold = 1'b0;
    logic [66:0] prev_out;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold) begin
                check("R8 held output", {out_addr, out_attr, out_err}, prev_out);
                check("R8 valid held", {66'd0, out_valid}, {66'd0, 1'b1});
            end
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = stall_mode ? lfsr[0] : 1'b1;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R7 unexpected output", {out_addr, out_attr, out_err}, 67'd0);
                end else begin
                    check(tag_q.pop_front(), {out_addr, out_attr, out_err}, exp_q.pop_front());
                end
            end
            prev_hold = out_valid && !out_ready;
            prev_out  = {out_addr, out_attr, out_err};
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < NE; i++) begin m_base[i] = '0; m_attr[i] = 2'b00; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        check("R1 out_valid", {66'd0, out_valid}, 67'd0);
        check("R1 req_ready", {66'd0, req_ready}, {66'd0, 1'b1});
        for (int i = 0; i < NE; i++) begin
            cfg_read("R1 lo zero", i, 1'b0, 32'd0);
            cfg_read("R1 hi zero", i, 1'b1, 32'd0);
        end
        send("R1 zero entry", 32'h0000_0ABC);

        // R2: write and read back with low-bit masking
        cfg_write(1, 1'b0, 32'h1234_5FFD);
        cfg_write(1, 1'b1, 32'hABCD_0001);
        cfg_read("R2 lo masked", 1, 1'b0, 32'h1234_5001);
        cfg_read("R2 hi", 1, 1'b1, 32'hABCD_0001);
        // R3, R4: 64-bit target
        send("R3 entry1 64-bit", 32'h0000_1ABC);
        send("R3 entry1 offset max", 32'h0000_1FFF);
        // R4: 32-bit target clears upper half
        cfg_write(2, 1'b1, 32'hFFFF_FFFF);
        cfg_write(2, 1'b0, 32'h8000_0000);
        send("R4 entry2 32-bit", 32'h0000_2123);
        // R5: reserved attributes
        cfg_write(3, 1'b0, 32'h0F00_0002);
        cfg_write(3, 1'b1, 32'h0000_0055);
        send("R5 attr 10", 32'h0000_3004);
        cfg_write(4, 1'b0, 32'h7777_7003);
        send("R5 attr 11", 32'h0000_4FF0);
        // R6: outside the window
        send("R6 first page past window", 32'h0000_6000);
        send("R6 page 7", 32'h0000_7010);
        send("R6 top address", 32'hFFFF_FFFF);
        send("R3 last entry", 32'h0000_5555);
        // R9: write and request in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd1; cfg_hi = 1'b1; cfg_wdata = 32'h0BAD_0000;
        req_valid = 1'b1; req_addr = 32'h0000_1040;
        #1 check("R9 ready", {66'd0, req_ready}, {66'd0, 1'b1});
        exp_q.push_back(model(32'h0000_1040));
        tag_q.push_back("R9 old entry value");
        @(posedge clk);
        #1 cfg_we = 1'b0; req_valid = 1'b0;
        model_write(1, 1'b1, 32'h0BAD_0000);
        send("R9 new entry value", 32'h0000_1040);
        // R7, R8: random stalls
        stall_mode = 1'b1;
        for (int k = 0; k < 40; k++) begin
            send("R8 stalled stream", AW'((k % 8) * 32'h1000 + k * 4));
        end
        stall_mode = 1'b0;
        for (int w = 0; w < 50 && exp_q.size() != 0; w++) @(posedge clk);
        check("R7 all results drained", {35'd0, 32'(exp_q.size())}, 67'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule